// File: doc/BRIEF.md
# SYSREF Slip Alignment and Margin Sequencer

This block is a control sequencer that lines up an externally divided SYSREF with the local timestamp counter. The clock chip that divides SYSREF can delay its output by one fast-clock period per request. That period is 1/8 of a timing-clock cycle. A sampler in the fabric compares the external SYSREF against an internal reference derived from the timestamp counter and reports one bit per valid pulse: 1 when the two agree, 0 when they disagree.

After a start pulse the sequencer measures first, then issues slip requests until the sampler reads 0. From there it keeps slipping until the sampler reads 1, which marks the aligned position. Each search phase allows at most `MAX_SLIPS` slips. Once aligned, it checks the setup/hold margin. It lowers the fine input-delay tap one step at a time from a fixed starting tap toward zero and looks for the tap at which the sample falls to 0. It then puts the tap back to the starting value and reports completion, an error code, the total slip count and the tap at which the sample changed.

After every slip or tap change it waits a programmable number of settling cycles. It then takes the first sampler valid pulse that arrives after that wait, so a slow external divider is never read before it has responded.

Top module: `sref_align_seq`

## Requirements
- R1: After reset and whenever idle, `tap_out` equals `START_TAP` (default 53) and `slip_req`, `busy`, `done` and `err` are 0.
- R2: `slip_req` is a one-cycle pulse that occurs only while `busy` is 1. A sample is only taken on a `smp_valid` pulse that arrives after at least `settle_cycles`+1 cycles have passed since the slip or tap change, so successive slip pulses are at least `settle_cycles`+1 cycles apart.
- R3: The first search phase takes a sample before any slip, then issues a slip after every sample that reads 1 and ends at the first sample that reads 0. If the first sample already reads 0, no slip is issued in this phase.
- R4: The second phase slips after every sample that reads 0 and ends at the first sample that reads 1. `slip_count` reports the total number of slip pulses issued in both phases.
- R5: Each phase allows at most `MAX_SLIPS` (default 128) slips. A sample that still reads the wrong value after `MAX_SLIPS` slips in that phase ends the run with `err`=1. The error code is `err_code`=1 in the first phase (no disagree region) and `err_code`=2 in the second (no agree region).
- R6: After alignment the tap is lowered by exactly 1 per step, starting from `START_TAP`-1. The first tap at which the sample reads 0 is reported on `edge_tap`, with `err_code`=0 and `err`=0.
- R7: If the sample still reads 1 at tap 0, the run ends with `err`=1, `err_code`=3 (margin not determined) and `edge_tap`=0.
- R8: When a run ends, whether it succeeds or fails, `tap_out` returns to `START_TAP` in the same cycle that `done` rises. `slip_count`, `edge_tap` and `err_code` are latched at that point.
- R9: `done` (and `err` with it) stays high until the next accepted start, which clears both.
- R10: A start pulse that arrives while `busy` is 1 is ignored, and the run in progress completes with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| settle_cycles | input | SETTLE_W | Settling wait after each slip or tap change |
| smp_valid | input | 1 | Sampler result valid pulse |
| smp_value | input | 1 | Sampler result: 1 agree, 0 disagree |
| slip_req | output | 1 | One-cycle request to delay the external SYSREF by one fast-clock period |
| tap_out | output | TAP_W | Fine input-delay tap |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, held until the next start |
| err | output | 1 | Run finished with an error |
| err_code | output | 2 | 0 none, 1 no disagree region, 2 no agree region, 3 margin not determined |
| slip_count | output | $clog2(2*MAX_SLIPS+1) | Total slips issued in the run |
| edge_tap | output | TAP_W | Tap at which the sample fell to 0 |

## Verification
The bench builds the block with its default parameters: a 6-bit tap starting at 53 and a 128-slip bound per phase. This means the full 128-slip error paths in both phases are actually reached, and so is a scan all the way down to tap 0. The settling count is a port rather than a parameter, so the bench varies it from 0 to 7 between runs, keeping every run to a few thousand cycles. A behavioural model of the divider counts slips modulo 128 against a 64-position agree window and a tap threshold. This lets edge taps at 52, 19 and 0, as well as stuck sampler values, be reached from chosen starting phases.

// File: rtl/sref_align_pkg.sv
package sref_align_pkg;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_NO_LOW    = 2'd1,
        ERR_NO_HIGH   = 2'd2,
        ERR_NO_MARGIN = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        PH_FIND_LOW,
        PH_FIND_HIGH,
        PH_SCAN
    } phase_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_RUN
    } seq_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_SETTLE,
        TM_WAIT
    } tmr_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SLIP,
        ACT_STEP,
        ACT_PASS,
        ACT_FAIL
    } act_e;

    typedef struct packed {
        logic valid;
        logic value;
    } sample_t;

endpackage

// File: rtl/sref_settle_wait.sv
module sref_settle_wait
    import sref_align_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic             smp_valid,
    input  logic             smp_value,
    output sample_t          smp_out
);

    tmr_e             st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= TM_IDLE;
            cnt     <= '0;
            smp_out <= '0;
        end else begin
            smp_out.valid <= 1'b0;
            unique case (st)
                TM_IDLE: begin
                    if (kick) begin
                        cnt <= settle_cycles;
                        st  <= TM_SETTLE;
                    end
                end
                TM_SETTLE: begin
                    if (cnt == '0) st <= TM_WAIT;
                    else           cnt <= cnt - 1'b1;
                end
                TM_WAIT: begin
                    // only a pulse seen after the wait counts as fresh
                    if (smp_valid) begin
                        smp_out.valid <= 1'b1;
                        smp_out.value <= smp_value;
                        st            <= TM_IDLE;
                    end
                end
                default: st <= TM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sref_seq_core.sv
module sref_seq_core
    import sref_align_pkg::*;
#(
    parameter int TAP_W     = 6,
    parameter int START_TAP = 53,
    parameter int MAX_SLIPS = 128,
    parameter int SLIP_W    = 9,
    parameter int PC_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  sample_t           smp,
    output logic              kick,
    output logic              slip_req,
    output logic              busy,
    output logic [TAP_W-1:0]  tap,
    output logic              done,
    output err_e              code,
    output logic [SLIP_W-1:0] slip_count,
    output logic [TAP_W-1:0]  edge_tap
);

    localparam logic [TAP_W-1:0] TAP0   = TAP_W'(START_TAP);
    localparam logic [PC_W-1:0]  PC_MAX = PC_W'(MAX_SLIPS);

    seq_e              st;
    phase_e            ph;
    phase_e            nph;
    act_e              act;
    err_e              fcode;
    logic [PC_W-1:0]   pcnt;
    logic [SLIP_W-1:0] total;

    assign busy = (st == SQ_RUN);

    // decision taken on each fresh sample
    always_comb begin
        act   = ACT_NONE;
        fcode = ERR_NONE;
        nph   = ph;
        if (st == SQ_RUN && smp.valid) begin
            unique case (ph)
                PH_FIND_LOW: begin
                    if (!smp.value) begin
                        act = ACT_SLIP;
                        nph = PH_FIND_HIGH;
                    end else if (pcnt == PC_MAX) begin
                        act   = ACT_FAIL;
                        fcode = ERR_NO_LOW;
                    end else begin
                        act = ACT_SLIP;
                    end
                end
                PH_FIND_HIGH: begin
                    if (smp.value) begin
                        nph = PH_SCAN;
                        if (tap == '0) begin
                            act   = ACT_FAIL;
                            fcode = ERR_NO_MARGIN;
                        end else begin
                            act = ACT_STEP;
                        end
                    end else if (pcnt == PC_MAX) begin
                        act   = ACT_FAIL;
                        fcode = ERR_NO_HIGH;
                    end else begin
                        act = ACT_SLIP;
                    end
                end
                PH_SCAN: begin
                    if (!smp.value) begin
                        act = ACT_PASS;
                    end else if (tap == '0) begin
                        act   = ACT_FAIL;
                        fcode = ERR_NO_MARGIN;
                    end else begin
                        act = ACT_STEP;
                    end
                end
                default: act = ACT_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            ph         <= PH_FIND_LOW;
            pcnt       <= '0;
            total      <= '0;
            tap        <= TAP0;
            kick       <= 1'b0;
            slip_req   <= 1'b0;
            done       <= 1'b0;
            code       <= ERR_NONE;
            slip_count <= '0;
            edge_tap   <= '0;
        end else begin
            kick     <= 1'b0;
            slip_req <= 1'b0;
            if (st == SQ_IDLE) begin
                if (start) begin
                    st    <= SQ_RUN;
                    done  <= 1'b0;
                    code  <= ERR_NONE;
                    ph    <= PH_FIND_LOW;
                    pcnt  <= '0;
                    total <= '0;
                    tap   <= TAP0;
                    kick  <= 1'b1;
                end
            end else begin
                unique case (act)
                    ACT_SLIP: begin
                        slip_req <= 1'b1;
                        kick     <= 1'b1;
                        total    <= total + 1'b1;
                        pcnt     <= (nph != ph) ? PC_W'(1) : pcnt + 1'b1;
                        ph       <= nph;
                    end
                    ACT_STEP: begin
                        tap  <= tap - 1'b1;
                        kick <= 1'b1;
                        ph   <= nph;
                    end
                    ACT_PASS: begin
                        st         <= SQ_IDLE;
                        done       <= 1'b1;
                        code       <= ERR_NONE;
                        slip_count <= total;
                        edge_tap   <= tap;
                        tap        <= TAP0;
                    end
                    ACT_FAIL: begin
                        st         <= SQ_IDLE;
                        done       <= 1'b1;
                        code       <= fcode;
                        slip_count <= total;
                        edge_tap   <= '0;
                        tap        <= TAP0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sref_align_seq.sv
module sref_align_seq
    import sref_align_pkg::*;
#(
    parameter int TAP_W     = 6,
    parameter int START_TAP = 53,
    parameter int MAX_SLIPS = 128,
    parameter int SETTLE_W  = 16,
    localparam int SLIP_W   = $clog2(2 * MAX_SLIPS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                smp_valid,
    input  logic                smp_value,
    output logic                slip_req,
    output logic [TAP_W-1:0]    tap_out,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [1:0]          err_code,
    output logic [SLIP_W-1:0]   slip_count,
    output logic [TAP_W-1:0]    edge_tap
);

    localparam int PC_W = $clog2(MAX_SLIPS + 1);

    logic    kick;
    sample_t smp;
    err_e    code;

    sref_settle_wait #(
        .CNT_W (SETTLE_W)
    ) u_wait (
        .clk           (clk),
        .rst           (rst),
        .kick          (kick),
        .settle_cycles (settle_cycles),
        .smp_valid     (smp_valid),
        .smp_value     (smp_value),
        .smp_out       (smp)
    );

    sref_seq_core #(
        .TAP_W     (TAP_W),
        .START_TAP (START_TAP),
        .MAX_SLIPS (MAX_SLIPS),
        .SLIP_W    (SLIP_W),
        .PC_W      (PC_W)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .smp        (smp),
        .kick       (kick),
        .slip_req   (slip_req),
        .busy       (busy),
        .tap        (tap_out),
        .done       (done),
        .code       (code),
        .slip_count (slip_count),
        .edge_tap   (edge_tap)
    );

    assign err_code = code;
    assign err      = (code != ERR_NONE);

endmodule

// File: rtl/sref_align_chk.sv
module sref_align_chk #(
    parameter int TAP_W     = 6,
    parameter int START_TAP = 53
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             slip_req,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [TAP_W-1:0] tap_out
);

    // R2
    slip_single_chk: assert property (@(posedge clk) disable iff (rst)
        slip_req |=> !slip_req);

    // R2
    slip_busy_chk: assert property (@(posedge clk) disable iff (rst)
        slip_req |-> busy);

    // R8
    idle_tap_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tap_out == TAP_W'(START_TAP)));

    // R6
    tap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tap_out != $past(tap_out)) |->
            (tap_out == TAP_W'($past(tap_out) - 1'b1) || tap_out == TAP_W'(START_TAP)));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R5
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

endmodule

bind sref_align_seq sref_align_chk #(
    .TAP_W     (TAP_W),
    .START_TAP (START_TAP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .slip_req (slip_req),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .tap_out  (tap_out)
);

// File: tb/tb_sref_align_seq.sv
module tb_sref_align_seq;

    localparam int START = 53;
    localparam int PER   = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] settle = 16'd0;
    logic        smp_valid = 1'b0;
    logic        smp_value;
    logic        slip_req;
    logic [5:0]  tap_out;
    logic        busy, done, err;
    logic [1:0]  err_code;
    logic [8:0]  slip_count;
    logic [5:0]  edge_tap;

    sref_align_seq dut (
        .clk(clk), .rst(rst), .start(start), .settle_cycles(settle),
        .smp_valid(smp_valid), .smp_value(smp_value), .slip_req(slip_req),
        .tap_out(tap_out), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .slip_count(slip_count), .edge_tap(edge_tap)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // divider and sampler model
    int ph = 0;
    int thr = 20;
    int mode = 0;
    int vcnt = 0;

    function automatic bit in_win(int p);
        return (p % PER) < 64;
    endfunction

    always @(posedge clk) if (slip_req) ph <= (ph + 1) % PER;

    always_comb begin
        if (mode == 1)      smp_value = 1'b1;
        else if (mode == 2) smp_value = 1'b0;
        else                smp_value = in_win(ph) && (int'(tap_out) >= thr);
    end

    always @(negedge clk) begin
        vcnt      <= (vcnt + 1) % 4;
        smp_valid <= (vcnt == 3);
    end

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // slip pulse monitor (R2)
    int  since = 0;
    bit  seen_slip = 0;
    bit  prev_slip = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (slip_req) begin
                if (prev_slip) chk(0, "R2 slip width", 2, 1);
                if (seen_slip && since < int'(settle) + 1)
                    chk(0, "R2 slip gap", since, int'(settle) + 1);
                if (!busy) chk(0, "R2 slip while idle", 0, 1);
                seen_slip = 1;
                since = 0;
            end else begin
                since++;
            end
            prev_slip = slip_req;
        end
    end

    // scoreboard
    typedef struct {
        int code;
        int slips;
        int edge_t;
    } exp_t;
    exp_t q[$];
    bit   done_seen = 0;

    always @(negedge clk) begin
        if (!rst && done && !done_seen) begin
            exp_t e;
            done_seen = 1;
            if (q.size() == 0) begin
                chk(0, "R10 unexpected completion", 1, 0);
            end else begin
                e = q.pop_front();
                chk(int'(err_code) == e.code, "R5 R7 err_code", err_code, e.code);
                chk(err == (e.code != 0), "R5 err flag", err, e.code != 0);
                chk(int'(slip_count) == e.slips, "R3 R4 slip_count", slip_count, e.slips);
                chk(int'(edge_tap) == e.edge_t, "R6 edge_tap", edge_tap, e.edge_t);
                chk(int'(tap_out) == START, "R8 tap restored", tap_out, START);
            end
        end
        if (!done) done_seen = 0;
    end

    task automatic push_exp(int p0, int th, int md);
        exp_t e;
        int   p = p0;
        int   n = 0;
        if (md == 1) begin
            e.code = 1; e.slips = 128; e.edge_t = 0;
        end else if (md == 2) begin
            e.code = 2; e.slips = 128; e.edge_t = 0;
        end else begin
            while (in_win(p))  begin p++; n++; end
            while (!in_win(p)) begin p++; n++; end
            e.slips = n;
            if (th == 0) begin e.code = 3; e.edge_t = 0; end
            else         begin e.code = 0; e.edge_t = th - 1; end
        end
        q.push_back(e);
    endtask

    task automatic run(int p0, int th, int md, int st, bit poke);
        @(negedge clk);
        ph = p0; thr = th; mode = md; settle = 16'(st);
        seen_slip = 0;
        push_exp(p0, th, md);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R9 start clears done", done, 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1;          // R10: must be ignored
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R10 still busy after start", busy, 1);
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(int'(tap_out) == START, "R1 reset tap", tap_out, START);
        chk(!busy && !done && !err && !slip_req, "R1 reset flags",
            {busy, done, err, slip_req}, 0);

        run(10, 20, 0, 7, 0);    // R3 R4 R6: starts aligned, 118 slips
        run(100, 53, 0, 0, 0);   // R3: first sample disagrees, edge 52
        run(63, 1, 0, 3, 0);     // R6: edge at tap 0
        run(70, 0, 0, 2, 0);     // R7: no margin transition
        run(0, 20, 1, 1, 0);     // R5: stuck at 1
        run(0, 20, 2, 1, 0);     // R5: stuck at 0
        run(5, 30, 0, 4, 1);     // R10: start while busy

        // R9: done held while idle
        repeat (15) @(negedge clk);
        chk(done == 1'b1, "R9 done held", done, 1);
        chk(busy == 1'b0 && int'(tap_out) == START, "R1 idle after run", tap_out, START);
        chk(q.size() == 0, "R10 all runs completed once", q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule